// File: doc/BRIEF.md
# Dual-Select SPI Configuration Register Slave

This block is an SPI slave that lets a host processor read and write a bank of 32 eight-bit configuration registers. Two active-low selects are provided: a configuration select and a data select. When both are low, the configuration select wins and the data path sees nothing. All SPI pins are brought into the system clock domain through two-flop synchronizers, and the SCK edges are detected there. SCK must run at no more than a quarter of the system clock rate.

A configuration transaction is a command byte followed by a data byte. The command byte is framed as follows:

- bit 7 is a start bit and must be 0;
- bit 6 selects the direction, 1 for read and 0 for write;
- bits 5..1 carry the register address;
- bit 0 is a stop bit and must be 0.

In a write, the second byte is stored in the addressed register. In a read, the addressed register is shifted out on SDO during the second byte. While the configuration select stays low, the bytes alternate between command and data, so several pairs can be sent in one select period. A byte received under the data select alone is handed to the system side as a one-cycle strobe carrying that byte. A parallel read port shows the register contents to the rest of the chip.

The control state machine has six states:

- IDLE: no select is active.
- CMD: waiting for a command byte.
- WR_DATA: a write command was accepted; the next byte is stored.
- RD_DATA: a read command was accepted; the register is being shifted out.
- SKIP: a badly framed command was received; the next byte is discarded.
- STREAM: the data channel is active.

Its transitions are:

- IDLE→CMD when the configuration select falls.
- IDLE→STREAM when only the data select falls.
- CMD→WR_DATA on a good write command.
- CMD→RD_DATA on a good read command.
- CMD→SKIP on a bad start or stop bit.
- WR_DATA, RD_DATA or SKIP→CMD on the next complete byte.
- STREAM→CMD when the configuration select takes over.
- Any configuration state→STREAM when only the data select remains low.
- Any state→IDLE when both selects are high.

Top module: `dual_sel_spi_regs`

## Requirements
- R1: SDI and SDO carry 8-bit bytes with the most significant bit first. SDI is sampled on the rising SCK edge, and SDO advances on the falling SCK edge, so bit 7 of a read value is on SDO before the first rising edge of the data byte.
- R2: The command byte 0,0,addr[4:0],0 (bit 7 down to bit 0) followed by a data byte writes that byte into register addr. The new value then appears on host_rdata when host_addr equals addr.
- R3: The command byte 0,1,addr[4:0],0 followed by any second byte shifts the contents of register addr out on SDO, MSB first, during that second byte.
- R4: While the configuration select stays low, bytes alternate command, data, command, data without any need to deselect.
- R5: If the active select rises before the eighth rising SCK edge of a byte, the partial byte has no effect. After a new select, the first byte is a command byte.
- R6: A command byte whose bit 7 or bit 0 is 1 is ignored, the byte after it writes no register, and the byte after that is again taken as a command.
- R7: With both selects low, traffic is decoded as configuration traffic and dat_valid never pulses.
- R8: With only dat_sel_n low, each complete byte produces exactly one cycle of dat_valid with dat_byte equal to that byte. Such bytes change no register, and SDO is 0 during them.
- R9: spi_sdo_oe is 1 only while a select is low (after the synchronizer delay). SDO is 0 whenever no read data byte is being sent, including during command bytes.
- R10: After reset all registers read 0, dat_valid is 0 and spi_sdo_oe is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | SPI serial clock from the host, idle low |
| spi_sdi | input | 1 | Serial data from the host |
| cfg_sel_n | input | 1 | Active-low configuration select; has priority |
| dat_sel_n | input | 1 | Active-low data-channel select |
| spi_sdo | output | 1 | Serial data to the host |
| spi_sdo_oe | output | 1 | Output enable for spi_sdo |
| host_addr | input | 5 | Parallel read address into the register bank |
| host_rdata | output | 8 | Register contents at host_addr |
| dat_valid | output | 1 | One-cycle strobe for a received data-channel byte |
| dat_byte | output | 8 | Byte received on the data channel |

## Verification
A bit counter that is off by one shows within the next byte in two ways: host_rdata holds a rotated value, and SDO shows a rotated read value. A byte phase left over after a deselect shows at once, because the next command byte gets written as data into whatever address was pending. A skip state that fails to return to CMD swallows the following valid write, so its register reads stale on the host port about a byte later. The bench sweeps every address for both write and read. It also drives aborts at several bit positions, both bad-framing cases, overlapping selects and several data-channel bytes, and compares each result against values computed arithmetically from the address.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 8;
    localparam int NREGS  = 1 << ADDR_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_WR_DATA,
        ST_RD_DATA,
        ST_SKIP,
        ST_STREAM
    } cfg_state_t;

    typedef enum logic [1:0] {
        CH_NONE,
        CH_CFG,
        CH_DAT
    } chan_t;
endpackage

// File: rtl/spi_sync_edge.sv
module spi_sync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_in,
    input  logic sdi_in,
    input  logic cfg_n_in,
    input  logic dat_n_in,
    output logic sck_rise,
    output logic sck_fall,
    output logic sdi_s,
    output logic cfg_act,
    output logic dat_act
);
    localparam int NSIG = 4;
    localparam logic [NSIG-1:0] RST_VAL = 4'b1100; // selects idle high

    logic [NSIG-1:0] raw;
    logic [NSIG-1:0] stage [SYNC_STAGES];
    logic [NSIG-1:0] synced;
    logic            sck_prev;

    assign raw    = {cfg_n_in, dat_n_in, sdi_in, sck_in};
    assign synced = stage[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SYNC_STAGES; s++) stage[s] <= RST_VAL;
            sck_prev <= 1'b0;
        end else begin
            stage[0] <= raw;
            for (int s = 1; s < SYNC_STAGES; s++) stage[s] <= stage[s-1];
            sck_prev <= synced[0];
        end
    end

    assign sck_rise = synced[0] & ~sck_prev;
    assign sck_fall = ~synced[0] & sck_prev;
    assign sdi_s    = synced[1];
    assign cfg_act  = ~synced[3];
    assign dat_act  = synced[3] & ~synced[2];
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         rise,
    input  logic         fall,
    input  logic         sdi,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done,
    output logic [W-1:0] byte_out,
    output logic         dout
);
    localparam int CNT_W = $clog2(W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

    logic [CNT_W-1:0] cnt;
    logic [W-1:0]     rx_sh;
    logic [W-1:0]     tx_sh;
    logic [W-1:0]     byte_q;
    logic             done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            rx_sh  <= '0;
            tx_sh  <= '0;
            byte_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (clr) begin
                cnt   <= '0;
                rx_sh <= '0;
                tx_sh <= '0;
            end else begin
                if (rise) begin
                    rx_sh <= {rx_sh[W-2:0], sdi};
                    if (cnt == LAST) begin
                        cnt    <= '0;
                        done_q <= 1'b1;
                        byte_q <= {rx_sh[W-2:0], sdi};
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                if (load)
                    tx_sh <= load_val;
                else if (fall && cnt != '0)
                    tx_sh <= {tx_sh[W-2:0], 1'b0};
            end
        end
    end

    assign done     = done_q;
    assign byte_out = byte_q;
    assign dout     = tx_sh[W-1];

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R1
endmodule

// File: rtl/spi_cfg_fsm.sv
module spi_cfg_fsm
    import spi_reg_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  chan_t         chan,
    input  logic          done,
    input  logic [DW-1:0] rx_byte,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] rd_addr,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [DW-1:0] wdata,
    output logic          load,
    output logic [DW-1:0] load_val,
    output logic          rx_valid,
    output logic [DW-1:0] rx_data,
    output cfg_state_t    state_o
);
    localparam int START_BIT = DW - 1;
    localparam int RW_BIT    = DW - 2;

    cfg_state_t    state_q, state_d;
    logic [AW-1:0] addr_q, addr_d;
    logic          cmd_ok;

    assign cmd_ok  = ~rx_byte[START_BIT] & ~rx_byte[0];
    assign rd_addr = rx_byte[AW:1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            addr_q  <= addr_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        addr_d   = addr_q;
        we       = 1'b0;
        load     = 1'b0;
        load_val = '0;
        rx_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (chan == CH_CFG)      state_d = ST_CMD;
                else if (chan == CH_DAT) state_d = ST_STREAM;
            end
            ST_CMD: begin
                if (done) begin
                    if (!cmd_ok) begin
                        state_d = ST_SKIP;
                    end else begin
                        addr_d = rx_byte[AW:1];
                        if (rx_byte[RW_BIT]) begin
                            state_d  = ST_RD_DATA;
                            load     = 1'b1;
                            load_val = rd_data;
                        end else begin
                            state_d = ST_WR_DATA;
                        end
                    end
                end
            end
            ST_WR_DATA: begin
                if (done && chan == CH_CFG) begin
                    we      = 1'b1;
                    state_d = ST_CMD;
                end
            end
            ST_RD_DATA: begin
                if (done) begin
                    load    = 1'b1;
                    state_d = ST_CMD;
                end
            end
            ST_SKIP: begin
                if (done) state_d = ST_CMD;
            end
            ST_STREAM: begin
                if (done && chan == CH_DAT) rx_valid = 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
        if (chan == CH_NONE)
            state_d = ST_IDLE;
        else if (chan == CH_CFG && state_q == ST_STREAM)
            state_d = ST_CMD;
        else if (chan == CH_DAT && state_q != ST_STREAM)
            state_d = ST_STREAM;
    end

    assign waddr   = addr_q;
    assign wdata   = rx_byte;
    assign rx_data = rx_byte;
    assign state_o = state_q;
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank #(
    parameter int AW = 5,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] ra_addr,
    output logic [DW-1:0] ra_data,
    input  logic [AW-1:0] rb_addr,
    output logic [DW-1:0] rb_data
);
    localparam int N = 1 << AW;

    logic [DW-1:0] mem [N];

    for (genvar i = 0; i < N; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mem[i] <= '0;
            else if (we && waddr == AW'(i))
                mem[i] <= wdata;
        end
    end

    assign ra_data = mem[ra_addr];
    assign rb_data = mem[rb_addr];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem[$past(waddr)] == $past(wdata)); // R2
endmodule

// File: rtl/dual_sel_spi_regs.sv
module dual_sel_spi_regs
    import spi_reg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_sdi,
    input  logic              cfg_sel_n,
    input  logic              dat_sel_n,
    output logic              spi_sdo,
    output logic              spi_sdo_oe,
    input  logic [ADDR_W-1:0] host_addr,
    output logic [DATA_W-1:0] host_rdata,
    output logic              dat_valid,
    output logic [DATA_W-1:0] dat_byte
);
    logic sck_rise, sck_fall, sdi_s, cfg_act, dat_act;
    chan_t chan, chan_q;
    logic clr;

    logic              done, load, we;
    logic [DATA_W-1:0] rx_byte, load_val, rd_data, wdata;
    logic [ADDR_W-1:0] rd_addr, waddr;
    cfg_state_t        state;

    spi_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .sck_in(spi_sck), .sdi_in(spi_sdi),
        .cfg_n_in(cfg_sel_n), .dat_n_in(dat_sel_n),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .sdi_s(sdi_s),
        .cfg_act(cfg_act), .dat_act(dat_act)
    );

    always_comb begin
        if (cfg_act)      chan = CH_CFG;
        else if (dat_act) chan = CH_DAT;
        else              chan = CH_NONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chan_q <= CH_NONE;
        else        chan_q <= chan;
    end

    assign clr = (chan == CH_NONE) || (chan != chan_q);

    spi_byte_shifter #(.W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .rise(sck_rise), .fall(sck_fall), .sdi(sdi_s),
        .load(load), .load_val(load_val),
        .done(done), .byte_out(rx_byte), .dout(spi_sdo)
    );

    spi_cfg_fsm #(.AW(ADDR_W), .DW(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .chan(chan), .done(done),
        .rx_byte(rx_byte), .rd_data(rd_data), .rd_addr(rd_addr),
        .we(we), .waddr(waddr), .wdata(wdata),
        .load(load), .load_val(load_val),
        .rx_valid(dat_valid), .rx_data(dat_byte), .state_o(state)
    );

    spi_reg_bank #(.AW(ADDR_W), .DW(DATA_W)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .we(we), .waddr(waddr), .wdata(wdata),
        .ra_addr(rd_addr), .ra_data(rd_data),
        .rb_addr(host_addr), .rb_data(host_rdata)
    );

    assign spi_sdo_oe = (chan != CH_NONE);

    AST_SDO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_RD_DATA) |-> !spi_sdo); // R9
    AST_VALID_NO_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        dat_valid |-> !cfg_act); // R7
    AST_NO_WRITE_IN_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STREAM) |-> !we); // R8
endmodule

// File: tb/dual_sel_spi_regs_test.sv
module dual_sel_spi_regs_test;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0, sdi = 1'b0, cfg_n = 1'b1, dat_n = 1'b1;
    logic       sdo, sdo_oe, dvalid;
    logic [4:0] haddr = '0;
    logic [7:0] hdata, dbyte;

    int checks = 0, failures = 0;
    int vcount = 0, vdouble = 0;
    logic [7:0] vlast = '0;
    logic prev_valid = 1'b0;
    logic [7:0] model [32];

    always #2 clk = ~clk;

    dual_sel_spi_regs uut (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_sdi(sdi),
        .cfg_sel_n(cfg_n), .dat_sel_n(dat_n),
        .spi_sdo(sdo), .spi_sdo_oe(sdo_oe),
        .host_addr(haddr), .host_rdata(hdata),
        .dat_valid(dvalid), .dat_byte(dbyte)
    );

    always @(negedge clk) begin
        if (dvalid) begin
            vcount++;
            vlast = dbyte;
            if (prev_valid) vdouble++;
        end
        prev_valid = dvalid;
    end

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 5) & 255);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic xfer_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
        rx = '0;
        for (int i = 0; i < n; i++) begin
            sdi = tx[7-i];
            repeat (HALF) @(negedge clk);
            rx[7-i] = sdo;
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        xfer_bits(tx, 8, rx);
    endtask

    task automatic sel(input logic c, input logic d);
        cfg_n = c; dat_n = d;
        repeat (6) @(negedge clk);
    endtask

    task automatic desel();
        repeat (HALF) @(negedge clk);
        cfg_n = 1'b1; dat_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    function automatic logic [7:0] wcmd(input int a);
        return {2'b00, 5'(a), 1'b0};
    endfunction

    function automatic logic [7:0] rcmd(input int a);
        return {2'b01, 5'(a), 1'b0};
    endfunction

    task automatic host_chk(input string req, input int a);
        haddr = 5'(a);
        @(negedge clk);
        chk(req, hdata, model[a]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] rx;
        int vbase;
        for (int a = 0; a < 32; a++) model[a] = '0;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R10 reset state
        chk("R10 oe", sdo_oe, 0);
        chk("R10 valid", dvalid, 0);
        host_chk("R10 reg0", 0);
        host_chk("R10 reg31", 31);

        // R2 / R4: write sweep with alternating pairs in one select
        sel(1'b0, 1'b1);
        chk("R9 oe high", sdo_oe, 1);
        for (int a = 0; a < 32; a++) begin
            xfer(wcmd(a), rx);
            xfer(pat(a), rx);
            model[a] = pat(a);
        end
        desel();
        chk("R9 oe low", sdo_oe, 0);
        for (int a = 0; a < 32; a++) host_chk("R2 R4 write", a);

        // R3 / R1: read sweep, MSB first on SDO; R9 quiet in command bytes
        sel(1'b0, 1'b1);
        for (int a = 0; a < 32; a++) begin
            xfer(rcmd(a), rx);
            chk("R9 sdo in cmd", rx, 0);
            xfer(8'h00, rx);
            chk("R3 R1 read", rx, model[a]);
        end
        desel();

        // R5: abort inside a data byte
        sel(1'b0, 1'b1);
        xfer(wcmd(4), rx);
        xfer_bits(8'hFF, 4, rx);
        desel();
        host_chk("R5 partial data", 4);
        sel(1'b0, 1'b1);
        xfer(wcmd(5), rx);
        xfer(8'h3C, rx);
        model[5] = 8'h3C;
        desel();
        host_chk("R5 fresh command", 5);
        host_chk("R5 no stray write", 4);
        // R5: abort inside a command byte
        sel(1'b0, 1'b1);
        xfer_bits(wcmd(10), 3, rx);
        desel();
        sel(1'b0, 1'b1);
        xfer(wcmd(10), rx);
        xfer(8'h6E, rx);
        model[10] = 8'h6E;
        desel();
        host_chk("R5 after cmd abort", 10);

        // R6: bad start bit, then bad stop bit
        sel(1'b0, 1'b1);
        xfer(8'h80 | wcmd(6), rx);
        xfer(8'h77, rx);
        xfer(wcmd(7), rx);
        xfer(8'h11, rx);
        model[7] = 8'h11;
        xfer(8'h01 | wcmd(6), rx);
        xfer(8'h55, rx);
        xfer(wcmd(11), rx);
        xfer(8'hA9, rx);
        model[11] = 8'hA9;
        desel();
        host_chk("R6 bad frame no write", 6);
        host_chk("R6 recover after start", 7);
        host_chk("R6 recover after stop", 11);

        // R7: both selects low, configuration wins
        vbase = vcount;
        sel(1'b1, 1'b0);
        sel(1'b0, 1'b0);
        xfer(wcmd(8), rx);
        xfer(8'h99, rx);
        model[8] = 8'h99;
        xfer(rcmd(8), rx);
        xfer(8'h00, rx);
        chk("R7 read under both", rx, 8'h99);
        desel();
        host_chk("R7 write under both", 8);
        chk("R7 no strobe", vcount, vbase);

        // R8: data channel alone
        sel(1'b1, 1'b0);
        chk("R9 oe data sel", sdo_oe, 1);
        for (int k = 0; k < 4; k++) begin
            vbase = vcount;
            xfer(8'((k * 77 + 27) & 255), rx);
            chk("R8 sdo zero", rx, 0);
            chk("R8 one strobe", vcount, vbase + 1);
            chk("R8 byte", vlast, (k * 77 + 27) & 255);
        end
        xfer(wcmd(9), rx);
        xfer(8'hEE, rx);
        desel();
        host_chk("R8 no write", 9);
        chk("R8 single cycle", vdouble, 0);
        chk("R9 oe idle", sdo_oe, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule